// File: doc/BRIEF.md
# Branch Condition and Link Unit

This block decides, for one branch or jump instruction, whether control flow is redirected and where it goes. It takes the two source register values, the carry flag, a 4-bit condition code, the current program counter and the immediate field from the instruction. It returns a taken flag and the next program counter. When the instruction asks for a link, it also returns a link write: a write enable, the return address and the destination register index.

The block is purely combinational. An execute stage feeds it the decoded operands and reads its outputs in the same cycle. It keeps no state and has no clock or reset. The condition code has two groups. Codes 0 to 7 cover equality, zero, carry and the two unconditional jumps, and use a 16-bit offset. Codes 8 to 15 cover signed and unsigned ordering, and use an 8-bit offset. Bit 3 of the code selects the group.

Top module: `br_link_unit`

## Requirements
- R1: Code 0 is taken when rs_a equals rs_b. Code 1 is taken when they differ.
- R2: Code 2 is taken when rs_a is zero. Code 3 is taken when rs_a is non-zero. rs_b has no effect on codes 2 and 3.
- R3: Code 4 is taken when carry_in is 1. Code 5 is taken when carry_in is 0.
- R4: The signed ordering codes compare rs_a with rs_b as two's-complement values. Code 8 is taken when rs_a < rs_b. Code 10 is taken when rs_a >= rs_b. Code 12 is taken when rs_a > rs_b. Code 14 is taken when rs_a <= rs_b.
- R5: The unsigned ordering codes make the same four tests on unsigned values. Code 9 tests <, code 11 tests >=, code 13 tests > and code 15 tests <=.
- R6: Code 6 (direct jump) and code 7 (register jump) are always taken.
- R7: For a taken branch with a code other than 7, next_pc is pc + 4 + 4 * offset. For codes 0 to 6 the offset is the sign-extended imm[15:0]. For codes 8 to 15 the offset is the sign-extended imm[7:0], and imm[15:8] has no effect. All sums wrap modulo 2^32.
- R8: For code 7 when taken, next_pc is rs_a with bits [1:0] cleared. imm has no effect.
- R9: When br_en is 0, taken is 0. When taken is 0, next_pc is pc + 4.
- R10: link_we is 1 exactly when br_en, link_req and taken are all 1. link_data is always pc + 4. link_idx is always rd_idx.
- R11: All outputs follow the inputs in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| br_en | input | 1 | Current instruction is a branch or jump |
| cond | input | 4 | Condition code (see R1 to R6) |
| link_req | input | 1 | Save the return address if taken |
| carry_in | input | 1 | Current carry flag |
| rs_a | input | 32 | First register operand |
| rs_b | input | 32 | Second register operand |
| pc | input | 32 | Address of the current instruction |
| imm | input | 16 | Immediate field of the instruction |
| rd_idx | input | 4 | Destination register index for the link |
| taken | output | 1 | Branch or jump is taken |
| next_pc | output | 32 | Next program counter |
| link_we | output | 1 | Write the return address to the register file |
| link_data | output | 32 | Return address |
| link_idx | output | 4 | Register index for the return address |

## Verification
The block holds no state, so an internal fault shows on the ports in the same evaluation as the inputs that expose it. A wrong borrow or sign term in the shared subtractor flips taken only for operand pairs that straddle the sign bit or the unsigned wrap. The sweep therefore pairs zero, all-ones, the most positive and most negative values, and small numbers of both signs. A wrong offset width or shift shows at once as a next_pc error. The chosen immediates have non-zero upper bytes and negative low bytes, and one program counter sits close to the top of the address space.

// File: rtl/br_link_pkg.sv
// Shared encodings for the branch condition and link unit.
// Assumes a 4-bit condition code. Bit 3 selects the ordering group,
// which uses the short offset.
package br_link_pkg;

    typedef enum logic [3:0] {
        BC_EQ   = 4'd0,
        BC_NE   = 4'd1,
        BC_Z    = 4'd2,
        BC_NZ   = 4'd3,
        BC_CS   = 4'd4,
        BC_CC   = 4'd5,
        BC_JMP  = 4'd6,
        BC_JREG = 4'd7,
        BC_LT   = 4'd8,
        BC_LTU  = 4'd9,
        BC_GE   = 4'd10,
        BC_GEU  = 4'd11,
        BC_GT   = 4'd12,
        BC_GTU  = 4'd13,
        BC_LE   = 4'd14,
        BC_LEU  = 4'd15
    } br_cond_e;

    localparam int COND_W = 4;

endpackage

// File: rtl/br_cond_eval.sv
// Condition evaluator. It decides whether the selected test holds on the
// operands. It assumes the width is at least 2 bits. One subtractor feeds
// both the signed and the unsigned comparisons.
module br_cond_eval
    import br_link_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [COND_W-1:0] cond,
    input  logic [XLEN-1:0]   op_a,
    input  logic [XLEN-1:0]   op_b,
    input  logic              carry,
    output logic              hit
);

    localparam int MSB = XLEN - 1;

    logic [XLEN:0] diff;
    logic          eq, is_zero, ult, slt;

    // Shared compare terms taken from one subtraction.
    always_comb begin
        diff    = {1'b0, op_a} - {1'b0, op_b};
        eq      = (diff[MSB:0] == '0);
        is_zero = (op_a == '0);
        ult     = diff[XLEN];
        slt     = (op_a[MSB] ^ op_b[MSB]) ? op_a[MSB] : diff[MSB];
    end

    // Pick the test that the condition code selects.
    always_comb begin
        unique case (br_cond_e'(cond))
            BC_EQ:   hit = eq;
            BC_NE:   hit = ~eq;
            BC_Z:    hit = is_zero;
            BC_NZ:   hit = ~is_zero;
            BC_CS:   hit = carry;
            BC_CC:   hit = ~carry;
            BC_JMP:  hit = 1'b1;
            BC_JREG: hit = 1'b1;
            BC_LT:   hit = slt;
            BC_LTU:  hit = ult;
            BC_GE:   hit = ~slt;
            BC_GEU:  hit = ~ult;
            BC_GT:   hit = ~slt & ~eq;
            BC_GTU:  hit = ~ult & ~eq;
            BC_LE:   hit = slt | eq;
            BC_LEU:  hit = ult | eq;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/br_target_gen.sv
// Target generator. It produces the sequential address and the branch
// target. It assumes instructions are 2**ALIGN_BITS bytes long.
// Relative offsets count instructions and are sign extended from either
// the long or the short immediate width.
module br_target_gen #(
    parameter int XLEN       = 32,
    parameter int IMM_W      = 16,
    parameter int SHORT_W    = 8,
    parameter int ALIGN_BITS = 2
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [IMM_W-1:0] imm,
    input  logic             short_sel,
    input  logic             reg_sel,
    input  logic [XLEN-1:0]  op_a,
    output logic [XLEN-1:0]  seq_pc,
    output logic [XLEN-1:0]  br_target
);

    localparam int              STEP       = 1 << ALIGN_BITS;
    localparam logic [XLEN-1:0] ALIGN_MASK = XLEN'(STEP - 1);

    logic [XLEN-1:0] off_long, off_short, off_sel, rel_target;

    // Sign-extend both offset forms.
    always_comb begin
        off_long  = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        off_short = {{(XLEN-SHORT_W){imm[SHORT_W-1]}}, imm[SHORT_W-1:0]};
    end

    // Select the offset, scale it and add it to the sequential address.
    always_comb begin
        seq_pc     = pc + XLEN'(STEP);
        off_sel    = short_sel ? off_short : off_long;
        rel_target = seq_pc + (off_sel << ALIGN_BITS);
    end

    // A register jump uses the register value with its low bits cleared.
    always_comb begin
        br_target = reg_sel ? (op_a & ~ALIGN_MASK) : rel_target;
    end

endmodule

// File: rtl/br_link_gen.sv
// Link generator. It builds the return-address write. It assumes the
// register file accepts a write in the same cycle as the branch.
module br_link_gen #(
    parameter int XLEN  = 32,
    parameter int IDX_W = 4
) (
    input  logic             br_en,
    input  logic             link_req,
    input  logic             taken,
    input  logic [XLEN-1:0]  seq_pc,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             link_we,
    output logic [XLEN-1:0]  link_data,
    output logic [IDX_W-1:0] link_idx
);

    // Write the link only for a taken branch that asks for one.
    always_comb begin
        link_we   = br_en & link_req & taken;
        link_data = seq_pc;
        link_idx  = rd_idx;
    end

endmodule

// File: rtl/br_link_unit.sv
// Branch condition and link unit, top level. It is combinational. It
// assumes the condition code is decoded from the instruction and that the
// ordering group (code bit 3) uses the short offset.
module br_link_unit
    import br_link_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int IMM_W      = 16,
    parameter int SHORT_W    = 8,
    parameter int IDX_W      = 4,
    parameter int ALIGN_BITS = 2
) (
    input  logic              br_en,
    input  logic [COND_W-1:0] cond,
    input  logic              link_req,
    input  logic              carry_in,
    input  logic [XLEN-1:0]   rs_a,
    input  logic [XLEN-1:0]   rs_b,
    input  logic [XLEN-1:0]   pc,
    input  logic [IMM_W-1:0]  imm,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              taken,
    output logic [XLEN-1:0]   next_pc,
    output logic              link_we,
    output logic [XLEN-1:0]   link_data,
    output logic [IDX_W-1:0]  link_idx
);

    logic            hit, short_sel, reg_sel;
    logic [XLEN-1:0] seq_pc, br_target;

    // Decode the offset form and the register-jump case from the code.
    always_comb begin
        short_sel = cond[COND_W-1];
        reg_sel   = (br_cond_e'(cond) == BC_JREG);
    end

    br_cond_eval #(.XLEN(XLEN)) u_eval (
        .cond  (cond),
        .op_a  (rs_a),
        .op_b  (rs_b),
        .carry (carry_in),
        .hit   (hit)
    );

    br_target_gen #(
        .XLEN(XLEN), .IMM_W(IMM_W), .SHORT_W(SHORT_W), .ALIGN_BITS(ALIGN_BITS)
    ) u_tgt (
        .pc        (pc),
        .imm       (imm),
        .short_sel (short_sel),
        .reg_sel   (reg_sel),
        .op_a      (rs_a),
        .seq_pc    (seq_pc),
        .br_target (br_target)
    );

    // Gate the test with br_en and choose the next program counter.
    always_comb begin
        taken   = br_en & hit;
        next_pc = taken ? br_target : seq_pc;
    end

    br_link_gen #(.XLEN(XLEN), .IDX_W(IDX_W)) u_link (
        .br_en     (br_en),
        .link_req  (link_req),
        .taken     (taken),
        .seq_pc    (seq_pc),
        .rd_idx    (rd_idx),
        .link_we   (link_we),
        .link_data (link_data),
        .link_idx  (link_idx)
    );

endmodule

// File: rtl/br_link_unit_chk.sv
// Checker for br_link_unit. It holds immediate assertions on port
// relations, because the block has no clock. It assumes the default
// code encoding.
module br_link_unit_chk #(
    parameter int XLEN       = 32,
    parameter int ALIGN_BITS = 2
) (
    input logic            br_en,
    input logic [3:0]      cond,
    input logic            link_req,
    input logic [XLEN-1:0] rs_a,
    input logic [XLEN-1:0] rs_b,
    input logic [XLEN-1:0] pc,
    input logic            taken,
    input logic [XLEN-1:0] next_pc,
    input logic            link_we
);

    localparam logic [XLEN-1:0] STEP = XLEN'(1 << ALIGN_BITS);

    // Port-level consistency rules.
    always_comb begin
        assert_idle_not_taken_R9: assert (br_en || !taken)
            else $error("taken while br_en is low");
        assert_fallthrough_R9: assert (taken || next_pc == pc + STEP)
            else $error("fall-through address wrong");
        assert_link_only_taken_R10: assert (!link_we || (taken && link_req))
            else $error("link write without taken link branch");
        assert_jump_always_R6: assert (!(br_en && (cond == 4'd6 || cond == 4'd7)) || taken)
            else $error("jump not taken");
        assert_jreg_aligned_R8: assert (!(taken && cond == 4'd7) || next_pc[ALIGN_BITS-1:0] == '0)
            else $error("register jump target misaligned");
        assert_eq_matches_R1: assert (!(br_en && cond == 4'd0) || taken == (rs_a == rs_b))
            else $error("equal test mismatch");
    end

endmodule

bind br_link_unit br_link_unit_chk #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_chk (
    .br_en    (br_en),
    .cond     (cond),
    .link_req (link_req),
    .rs_a     (rs_a),
    .rs_b     (rs_b),
    .pc       (pc),
    .taken    (taken),
    .next_pc  (next_pc),
    .link_we  (link_we)
);

// File: tb/tb_br_link_unit.sv
// Bench for br_link_unit. It sweeps every condition code against a set of
// boundary operands, both carry values, link and enable. Expected values
// come from plain signed and unsigned arithmetic.
module tb_br_link_unit;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        br_en, link_req, carry_in;
    logic [3:0]  cond, rd_idx;
    logic [31:0] rs_a, rs_b, pc, next_pc, link_data;
    logic [15:0] imm;
    logic        taken, link_we;
    logic [3:0]  link_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    br_link_unit dut (
        .br_en(br_en), .cond(cond), .link_req(link_req), .carry_in(carry_in),
        .rs_a(rs_a), .rs_b(rs_b), .pc(pc), .imm(imm), .rd_idx(rd_idx),
        .taken(taken), .next_pc(next_pc), .link_we(link_we),
        .link_data(link_data), .link_idx(link_idx)
    );

    logic [31:0] ops  [6] = '{32'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h5, 32'hFFFF_FFFB};
    logic [15:0] imms [6] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFF80, 16'h1234, 16'h00FF};
    logic [31:0] pcs  [3] = '{32'h0000_1000, 32'hFFFF_FFF0, 32'h8000_0000};

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd0, 4'd1: return "R1";
            4'd2, 4'd3: return "R2";
            4'd4, 4'd5: return "R3";
            4'd6, 4'd7: return "R6";
            4'd8, 4'd10, 4'd12, 4'd14: return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic bit exp_hit(input logic [3:0] c, input logic [31:0] a,
                                   input logic [31:0] b, input logic cy);
        case (c)
            4'd0:  return a == b;
            4'd1:  return a != b;
            4'd2:  return a == 0;
            4'd3:  return a != 0;
            4'd4:  return cy;
            4'd5:  return !cy;
            4'd6, 4'd7: return 1'b1;
            4'd8:  return $signed(a) <  $signed(b);
            4'd9:  return a <  b;
            4'd10: return $signed(a) >= $signed(b);
            4'd11: return a >= b;
            4'd12: return $signed(a) >  $signed(b);
            4'd13: return a >  b;
            4'd14: return $signed(a) <= $signed(b);
            default: return a <= b;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        br_en = 0; link_req = 0; carry_in = 0; cond = 4'd6;
        rs_a = 0; rs_b = 0; pc = 32'h100; imm = 16'h0010; rd_idx = 4'd3;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Idle state, and outputs that follow the inputs in the same cycle (R11).
        check("R9", "idle taken", {31'b0, taken}, 32'd0);
        check("R9", "idle next_pc", next_pc, 32'h104);
        check("R10", "idle link_we", {31'b0, link_we}, 32'd0);
        check("R10", "idle link_data", link_data, 32'h104);

        for (int c = 0; c < 16; c++)
        for (int ia = 0; ia < 6; ia++)
        for (int ib = 0; ib < 6; ib++)
        for (int cy = 0; cy < 2; cy++)
        for (int lk = 0; lk < 2; lk++)
        for (int en = 0; en < 2; en++) begin
            logic        e_tk;
            logic [31:0] e_pc, seq;
            logic signed [31:0] off;
            string       rq;
            @(posedge clk);
            cond     = 4'(c);
            rs_a     = ops[ia];
            rs_b     = ops[ib];
            carry_in = cy[0];
            link_req = lk[0];
            br_en    = en[0];
            imm      = imms[(ia + ib + c) % 6];
            pc       = pcs[(ib + cy) % 3];
            rd_idx   = 4'(c + ia);
            @(negedge clk);
            e_tk = en[0] && exp_hit(4'(c), ops[ia], ops[ib], cy[0]);
            seq  = pc + 32'd4;
            rq   = req_of(4'(c));
            if (c >= 8) off = $signed(imm[7:0]);
            else        off = $signed(imm);
            if (!e_tk)       e_pc = seq;
            else if (c == 7) e_pc = rs_a & 32'hFFFF_FFFC;
            else             e_pc = seq + 32'(off * 4);
            check(en[0] ? rq : "R9", "taken", {31'b0, taken}, {31'b0, e_tk});
            check(!e_tk ? "R9" : (c == 7 ? "R8" : "R7"), "next_pc", next_pc, e_pc);
            check("R10", "link_we", {31'b0, link_we}, {31'b0, e_tk && lk[0]});
            check("R10", "link_data", link_data, seq);
            check("R10", "link_idx", {28'b0, link_idx}, {28'b0, rd_idx});
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule